// File: doc/BRIEF.md
# Watchdog Reset Timer

This block guards a processor against a stalled program. It runs from the doubled oscillator clock, which is twice the crystal frequency. A free-running prescaler feeds a timeout counter. If software does not service the block before the counter overflows, the block drives an active-low reset line for a fixed number of cycles. It also sets a sticky flag that records the watchdog as the reset cause.

Software services the watchdog by writing any value to its register address. Only the upper prescaler bits and the counter are cleared by that write; the low prescaler bits keep running. A read of the same address returns a constant byte taken from an input port, not watchdog state. A stop-mode entry clears the prescaler. A power-on indication clears the prescaler after a fixed delay. The watchdog is held off while a test-voltage condition is present in monitor mode, and while the debug break state is active.

Top module: `wdog_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `rst_n_o` is 1, `wd_flag` is 0 and `rd_data` is 0. Both the prescaler and the counter start from zero.
- R2: With no service, no clear and no disable, `rst_n_o` goes low on exactly clock edge 2^(PRE_W+CNT_W), counted from the first edge after `rst` is released.
- R3: `rst_n_o` stays low for exactly PULSE_LEN cycles. While it is low, the prescaler and the counter are held at zero. The next timeout therefore comes 2^(PRE_W+CNT_W) edges after the edge that ends the pulse.
- R4: `wd_flag` rises on the same edge that drives `rst_n_o` low. It stays 1 after the pulse ends, until `flag_clr` is sampled high. A new expiry on that same edge wins over the clear.
- R5: A write (`wr_en` high) with any `wr_data` clears the counter. The same write clears the prescaler bits from SVC_LO upward and increments the bits below SVC_LO. If p is the prescaler value before the write, the next timeout follows 2^(PRE_W+CNT_W) - ((p mod 2^SVC_LO) + 1) edges after the write edge.
- R6: `rd_en` sampled high puts `vec_lo` on `rd_data` one cycle later; otherwise `rd_data` is 0. Reads do not service the watchdog.
- R7: A `stop_req` sampled high sets the prescaler to zero and leaves the counter value unchanged.
- R8: A `por_pulse` sampled on edge P sets the prescaler to zero on edge P+POR_DLY. The counter is not changed.
- R9: While `test_dis` or `brk_act` is high, the prescaler and the counter are held at zero and no reset pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Doubled oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| por_pulse | input | 1 | Power-on indication, starts the delayed prescaler clear |
| stop_req | input | 1 | Stop-mode entry, clears the prescaler |
| test_dis | input | 1 | Test voltage present in monitor mode, disables the watchdog |
| brk_act | input | 1 | Debug break state, disables the watchdog |
| wr_en | input | 1 | Write strobe to the service register |
| wr_data | input | DATA_W | Write data, value ignored |
| rd_en | input | 1 | Read strobe to the service register |
| vec_lo | input | DATA_W | Constant byte returned on reads |
| rd_data | output | DATA_W | Registered read data |
| flag_clr | input | 1 | Clears the sticky watchdog flag |
| rst_n_o | output | 1 | Active-low reset drive |
| wd_flag | output | 1 | Sticky watchdog-caused-reset flag |

## Verification
A wrong prescaler or counter value has no effect at the ports until the next expiry. It then shows as a reset edge that comes early or late. That can be up to 2^(PRE_W+CNT_W) cycles after the fault. The bench therefore measures every timeout to the exact edge after reset, after a service, after a stop, after a power-on clear and after a disable window. An error in the amount a service clears, or in the power-on delay, then shows as a fixed offset in that count. A fault in the pulse or flag logic shows within PULSE_LEN cycles of the first expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Control strobes shared by the prescaler and the timeout counter
  typedef struct packed {
    logic hold;     // pulse active or watchdog disabled: force zero
    logic pre_clr;  // stop entry or delayed power-on clear
    logic svc;      // service write
  } wd_ctl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int PRE_W  = 13,
  parameter int SVC_LO = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  wd_ctl_t ctl,
  output logic    carry
);
  localparam logic [PRE_W-1:0] LOW_MASK =
    {{(PRE_W-SVC_LO){1'b0}}, {SVC_LO{1'b1}}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || ctl.hold || ctl.pre_clr)
      pre_q <= '0;
    else if (ctl.svc)
      pre_q <= (pre_q & LOW_MASK) + PRE_W'(1);
    else
      pre_q <= pre_q + PRE_W'(1);
  end

  // Carry out of the top bit only when the prescaler truly wraps
  assign carry = ~(ctl.hold | ctl.pre_clr | ctl.svc) & (&pre_q);
endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout
  import wdog_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic    clk,
  input  logic    rst,
  input  wd_ctl_t ctl,
  input  logic    carry,
  output logic    expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || ctl.hold || ctl.svc)
      cnt_q <= '0;
    else if (carry)
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expire = carry & (&cnt_q);
endmodule

// File: rtl/wdog_por_delay.sv
module wdog_por_delay #(
  parameter int POR_DLY = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic por,
  output logic clr_o
);
  generate
    if (POR_DLY == 0) begin : g_direct
      assign clr_o = por;
    end else begin : g_count
      localparam int DW = (POR_DLY < 2) ? 1 : $clog2(POR_DLY);
      logic [DW-1:0] dcnt_q;
      logic          busy_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q <= 1'b0;
          dcnt_q <= '0;
        end else if (por) begin
          busy_q <= 1'b1;
          dcnt_q <= DW'(POR_DLY - 1);
        end else if (busy_q) begin
          if (dcnt_q == '0) busy_q <= 1'b0;
          else              dcnt_q <= dcnt_q - DW'(1);
        end
      end

      assign clr_o = busy_q & (dcnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic flag_clr,
  output logic active,
  output logic rst_n_o,
  output logic flag
);
  localparam int PW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN);

  logic [PW-1:0] pcnt_q;
  logic          act_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (fire && !act_q) begin
      act_q  <= 1'b1;
      pcnt_q <= PW'(PULSE_LEN - 1);
    end else if (act_q) begin
      if (pcnt_q == '0) act_q  <= 1'b0;
      else              pcnt_q <= pcnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (fire)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign active  = act_q;
  assign rst_n_o = ~act_q;
  assign flag    = flag_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_W     = 13,
  parameter int SVC_LO    = 5,
  parameter int CNT_W     = 6,
  parameter int PULSE_LEN = 32,
  parameter int POR_DLY   = 4096,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_pulse,
  input  logic              stop_req,
  input  logic              test_dis,
  input  logic              brk_act,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] vec_lo,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flag_clr,
  output logic              rst_n_o,
  output logic              wd_flag
);
  wd_ctl_t ctl;
  logic    pulse_act;
  logic    por_clr;
  logic    carry;
  logic    expire;
  logic    unused_wdata;

  // Written value carries no meaning; only the strobe services the watchdog
  assign unused_wdata = ^wr_data;

  assign ctl.hold    = pulse_act | test_dis | brk_act;
  assign ctl.pre_clr = stop_req | por_clr;
  assign ctl.svc     = wr_en;

  wdog_por_delay #(.POR_DLY(POR_DLY)) u_por (
    .clk   (clk),
    .rst   (rst),
    .por   (por_pulse),
    .clr_o (por_clr)
  );

  wdog_prescaler #(.PRE_W(PRE_W), .SVC_LO(SVC_LO)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .carry (carry)
  );

  wdog_timeout #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .carry  (carry),
    .expire (expire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk      (clk),
    .rst      (rst),
    .fire     (expire),
    .flag_clr (flag_clr),
    .active   (pulse_act),
    .rst_n_o  (rst_n_o),
    .flag     (wd_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= vec_lo;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int PULSE_LEN = 32,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              test_dis,
  input logic              brk_act,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] vec_lo,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag_clr,
  input logic              rst_n_o,
  input logic              wd_flag
);
  localparam int LW = $clog2(PULSE_LEN + 1) + 1;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || rst_n_o) low_cnt <= '0;
    else                low_cnt <= low_cnt + LW'(1);
  end

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> low_cnt == LW'(PULSE_LEN));

  a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |-> low_cnt < LW'(PULSE_LEN));

  a_r4_flag_on_fire: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> wd_flag);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    wd_flag && !flag_clr |=> wd_flag);

  a_r5_service_blocks_fire: assert property (@(posedge clk) disable iff (rst)
    wr_en && rst_n_o |=> rst_n_o);

  a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(vec_lo));

  a_r9_disabled_no_fire: assert property (@(posedge clk) disable iff (rst)
    (test_dis || brk_act) && rst_n_o |=> rst_n_o);
endmodule

bind wdog_top wdog_checker #(.PULSE_LEN(PULSE_LEN), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .test_dis (test_dis),
  .brk_act  (brk_act),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .vec_lo   (vec_lo),
  .rd_data  (rd_data),
  .flag_clr (flag_clr),
  .rst_n_o  (rst_n_o),
  .wd_flag  (wd_flag)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  localparam int PRE_W  = 6;
  localparam int SVC_LO = 3;
  localparam int CNT_W  = 3;
  localparam int PLEN   = 32;
  localparam int PDLY   = 40;
  localparam int TMO    = 1 << (PRE_W + CNT_W);   // 512

  // vector: [18:3] cycles to run, [2:1] mode, [0] expect a pulse
  // mode 0 free run, 1 test_dis held, 2 brk_act held, 3 service every 400
  localparam logic [18:0] VECS [0:8] = '{
    {16'd100,  2'd0, 1'b0},
    {16'd511,  2'd0, 1'b0},
    {16'd512,  2'd0, 1'b1},
    {16'd513,  2'd0, 1'b1},
    {16'd600,  2'd0, 1'b1},
    {16'd700,  2'd1, 1'b0},
    {16'd700,  2'd2, 1'b0},
    {16'd2000, 2'd1, 1'b0},
    {16'd3000, 2'd3, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_pulse = 1'b0, stop_req = 1'b0, test_dis = 1'b0, brk_act = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = 8'h00, vec_lo = 8'h3C;
  logic [7:0] rd_data;
  logic       rst_n_o, wd_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wdog_top #(.PRE_W(PRE_W), .SVC_LO(SVC_LO), .CNT_W(CNT_W),
             .PULSE_LEN(PLEN), .POR_DLY(PDLY), .DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .por_pulse(por_pulse), .stop_req(stop_req),
    .test_dis(test_dis), .brk_act(brk_act), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .vec_lo(vec_lo), .rd_data(rd_data), .flag_clr(flag_clr),
    .rst_n_o(rst_n_o), .wd_flag(wd_flag));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R2: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  // ticks until rst_n_o is seen low, capped
  task automatic measure(output int n);
    n = 0;
    while (n < 3000) begin
      tick();
      n = n + 1;
      if (!rst_n_o) break;
    end
  endtask

  initial begin
    int n;
    int w;
    logic fired;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) tick();
    // R1 reset state
    chk("R1 rst_n_o in reset", rst_n_o, 1);
    chk("R1 flag in reset", wd_flag, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    rst = 1'b0;
    tick();
    chk("R1 rst_n_o after release", rst_n_o, 1);
    chk("R1 rd_data after release", rd_data, 0);

    // vector table: R2 boundaries, R9 disables, R5 periodic service
    for (int v = 0; v < 9; v++) begin
      int   cycles;
      logic [1:0] mode;
      cycles = int'(VECS[v][18:3]);
      mode   = VECS[v][2:1];
      do_reset();
      test_dis = (mode == 2'd1);
      brk_act  = (mode == 2'd2);
      fired = 1'b0;
      for (int i = 0; i < cycles; i++) begin
        wr_en = (mode == 2'd3) && (i % 400 == 399);
        tick();
        if (!rst_n_o) fired = 1'b1;
      end
      wr_en = 1'b0; test_dis = 1'b0; brk_act = 1'b0;
      case (mode)
        2'd0:    chk("R2 table", fired, VECS[v][0]);
        2'd3:    chk("R5 table", fired, VECS[v][0]);
        default: chk("R9 table", fired, VECS[v][0]);
      endcase
    end

    // R2 exact timeout, R3 pulse width and restart, R4 flag
    do_reset();
    measure(n);
    chk("R2 timeout edges", n, TMO);
    chk("R4 flag at pulse start", wd_flag, 1);
    w = 1;
    while (w < 100) begin
      tick();
      if (rst_n_o) break;
      w = w + 1;
    end
    chk("R3 pulse width", w, PLEN);
    chk("R4 flag after pulse", wd_flag, 1);
    measure(n);
    chk("R3 next timeout", n, TMO);
    while (!rst_n_o) tick();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R4 flag cleared", wd_flag, 0);

    // R1 reset during a pulse
    do_reset();
    measure(n);
    repeat (5) tick();
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset ends pulse", rst_n_o, 1);
    chk("R1 reset clears flag", wd_flag, 0);

    // R5 service keeps low prescaler bits
    do_reset();
    repeat (29) tick();
    wr_data = 8'hA5; wr_en = 1'b1; tick(); wr_en = 1'b0;
    measure(n);
    chk("R5 service at 29", n, TMO - ((29 % 8) + 1));
    do_reset();
    repeat (60) tick();
    wr_data = 8'h00; wr_en = 1'b1; tick(); wr_en = 1'b0;
    measure(n);
    chk("R5 service at 60 data 0", n, TMO - ((60 % 8) + 1));

    // R6 read path and reads not servicing
    do_reset();
    vec_lo = 8'h3C; rd_en = 1'b1; tick();
    chk("R6 read value", rd_data, 8'h3C);
    vec_lo = 8'hC3; tick();
    chk("R6 read follows input", rd_data, 8'hC3);
    rd_en = 1'b0; tick();
    chk("R6 idle read data", rd_data, 0);
    do_reset();
    rd_en = 1'b1;
    measure(n);
    rd_en = 1'b0;
    chk("R6 reads do not service", n, TMO);

    // R7 stop clears prescaler, keeps counter (value 100 -> 64)
    do_reset();
    repeat (100) tick();
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    measure(n);
    chk("R7 stop clear", n, TMO - 64);

    // R8 power-on clear after the delay
    do_reset();
    por_pulse = 1'b1; tick(); por_pulse = 1'b0;
    measure(n);
    chk("R8 delayed power-on clear", n, PDLY + TMO);

    // R9 disable holds at zero, full interval after release
    do_reset();
    repeat (100) tick();
    test_dis = 1'b1; repeat (50) tick(); test_dis = 1'b0;
    measure(n);
    chk("R9 after test_dis", n, TMO);
    do_reset();
    repeat (300) tick();
    brk_act = 1'b1; repeat (900) tick(); brk_act = 1'b0;
    chk("R9 no pulse during break", rst_n_o, 1);
    measure(n);
    chk("R9 after brk_act", n, TMO);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule